// File: doc/BRIEF.md
# Memory read latency monitor

The block observes read traffic between a coherent fabric edge and a set of DRAM controller channels (three by default). For every channel it keeps a live count of reads that have been issued and not yet completed. While counting is active it adds that live count into a per-channel latency accumulator on every cycle, and counts the issued reads in a separate per-channel request counter. A single free-running cycle counter shared by all channels gives the time base. Each request stands for one 32-byte transfer and adds one to its counter.

Software reaches the block through a flat 64-bit register port with a write strobe, a byte offset and a combinational read-data path. A gate register opens or closes the counting logic. A control register starts, stops or clears counting. A sticky overflow status register records any counter that wrapped. Average read latency in cycles is the accumulator of a channel divided by its request counter. The cycle counter converts that figure to time.

Top module: `rd_lat_mon`

## Requirements
- R1: The cycle counter adds one on each clock edge at which counting is active. Counting is active when the run flag is set and the gate register reads 1. Otherwise the counter holds.
- R2: While counting is active, the request counter of channel c adds one on each edge at which `rd_issue_i[c]` is high. The count is one per request, not per byte.
- R3: While counting is active, the accumulator of channel c adds that channel's in-flight count, as it stood before the edge, on every edge.
- R4: The in-flight count of a channel rises by one on issue and falls by one on completion. Issue and completion in the same cycle leave it unchanged. A completion with nothing in flight is ignored, and the count saturates at its maximum. The tracker keeps running while counting is stopped or gated, and the clear command does not reset it.
- R5: Control register (offset 0x808), decoded on the full 64-bit write value: 0 clears the run flag, 1 sets it, 2 is the clear command. Any other value is ignored. A read returns the run flag in bit 0.
- R6: Gate register (offset 0x800): write bit 0 opens (1) or closes (0) the counting logic, and a read returns it in bit 0. With the gate closed, every counter and status bit holds even while the run flag is set.
- R7: The clear command takes effect only while the gate reads 1. It zeroes every counter and status bit and clears the run flag, so the next enable starts every counter from zero. Written while the gate reads 0, it changes nothing.
- R8: A counter that wraps past its maximum restarts from the wrapped value and sets its sticky status bit. Only the clear command resets these bits. Status register (offset 0x810) bits: 0 cycles; 1, 4 and 7 accumulators of channels 0, 1 and 2; 3, 6 and 9 request counters of channels 0, 1 and 2. All other bits read 0.
- R9: Read-only offsets are cycles 0x818; channel 0 requests 0x820 and accumulator 0x830; channel 1 at 0x838 and 0x848; channel 2 at 0x850 and 0x860. Counters read zero-extended. Writes to these offsets and to the status register have no effect. Any other offset, including unaligned ones, reads zero.
- R10: After reset, every register reads zero and every in-flight count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_issue_i | input | NUM_CH | One pulse per read issued on each channel |
| rd_done_i | input | NUM_CH | One pulse per read completed on each channel |
| csr_we_i | input | 1 | Register write strobe |
| csr_addr_i | input | 12 | Register byte offset for read and write |
| csr_wdata_i | input | 64 | Register write data |
| csr_rdata_o | output | 64 | Read data for `csr_addr_i`, combinational |

## Verification
Several rules are checked on every cycle by assertions:
- the cycle counter holds when counting is inactive and steps by one when it is active;
- a channel's in-flight count stays unchanged under simultaneous issue and completion, and never drops below zero;
- status bits stay set once set;
- a clear command leaves the counters and status at zero.

Other behaviour only shows in the bench's scenarios, which compare every register against a reference model on every clock:
- latency sums under mixed traffic patterns;
- the ignored control codes and the clear command written while gated;
- writes to read-only offsets and reads of unmapped offsets;
- wrap-around of every counter kind with the sticky bits at their positions.

// File: rtl/rd_lat_pkg.sv
package rd_lat_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 64;

  localparam logic [ADDR_W-1:0] OFS_GATE = 12'h800;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h808;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h810;
  localparam logic [ADDR_W-1:0] OFS_CYC  = 12'h818;
  localparam logic [ADDR_W-1:0] OFS_REQ0 = 12'h820;
  localparam logic [ADDR_W-1:0] OFS_ACC0 = 12'h830;
  localparam logic [ADDR_W-1:0] CH_STRIDE = 12'h018;

  typedef enum logic [1:0] {
    CMD_STOP  = 2'd0,
    CMD_RUN   = 2'd1,
    CMD_CLEAR = 2'd2
  } ctrl_cmd_e;

  function automatic logic [ADDR_W-1:0] ofs_req(input int unsigned ch);
    return OFS_REQ0 + ADDR_W'(ch * CH_STRIDE);
  endfunction

  function automatic logic [ADDR_W-1:0] ofs_acc(input int unsigned ch);
    return OFS_ACC0 + ADDR_W'(ch * CH_STRIDE);
  endfunction

  // status layout: bit 0 cycles, then three bits per channel
  function automatic int unsigned stat_acc_bit(input int unsigned ch);
    return 1 + 3 * ch;
  endfunction

  function automatic int unsigned stat_req_bit(input int unsigned ch);
    return 3 + 3 * ch;
  endfunction
endpackage

// File: rtl/rd_lat_inflight.sv
module rd_lat_inflight #(
  parameter int unsigned OUT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic             done_i,
  output logic [OUT_W-1:0] cnt_o
);
  logic [OUT_W-1:0] cnt_q;
  logic             up, dn;

  assign up = issue_i && !done_i && (cnt_q != '1);
  assign dn = done_i && !issue_i && (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  cnt_q <= '0;
    else if (up)  cnt_q <= cnt_q + 1'b1;
    else if (dn)  cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rd_lat_accum.sv
module rd_lat_accum #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned ADD_W = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [ADD_W-1:0] add_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam int unsigned PAD_W = CNT_W + 1 - ADD_W;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [CNT_W:0]   sum;

  assign sum = {1'b0, cnt_q} + {{PAD_W{1'b0}}, add_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (en_i) begin
      cnt_q <= sum[CNT_W-1:0];
      if (sum[CNT_W]) ovf_q <= 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/rd_lat_csr.sv
module rd_lat_csr
  import rd_lat_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CNT_W  = 64
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [DATA_W-1:0]       wdata_i,
  output logic [DATA_W-1:0]       rdata_o,
  input  logic [CNT_W-1:0]        cyc_i,
  input  logic [NUM_CH*CNT_W-1:0] req_i,
  input  logic [NUM_CH*CNT_W-1:0] acc_i,
  input  logic [DATA_W-1:0]       stat_i,
  output logic                    gate_o,
  output logic                    cnt_en_o,
  output logic                    clr_o
);
  logic gate_q, run_q;
  logic wr_gate, wr_ctrl, cmd_stop, cmd_run;

  assign wr_gate  = we_i && (addr_i == OFS_GATE);
  assign wr_ctrl  = we_i && (addr_i == OFS_CTRL);
  assign cmd_stop = wr_ctrl && (wdata_i == DATA_W'(CMD_STOP));
  assign cmd_run  = wr_ctrl && (wdata_i == DATA_W'(CMD_RUN));
  // clear is only honoured while the counting logic is ungated
  assign clr_o    = wr_ctrl && (wdata_i == DATA_W'(CMD_CLEAR)) && gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
      run_q  <= 1'b0;
    end else begin
      if (wr_gate) gate_q <= wdata_i[0];
      if (clr_o || cmd_stop) run_q <= 1'b0;
      else if (cmd_run)      run_q <= 1'b1;
    end
  end

  assign gate_o   = gate_q;
  assign cnt_en_o = gate_q && run_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_GATE) rdata_o = DATA_W'(gate_q);
    if (addr_i == OFS_CTRL) rdata_o = DATA_W'(run_q);
    if (addr_i == OFS_STAT) rdata_o = stat_i;
    if (addr_i == OFS_CYC)  rdata_o = DATA_W'(cyc_i);
    for (int unsigned c = 0; c < NUM_CH; c++) begin
      if (addr_i == ofs_req(c)) rdata_o = DATA_W'(req_i[c*CNT_W +: CNT_W]);
      if (addr_i == ofs_acc(c)) rdata_o = DATA_W'(acc_i[c*CNT_W +: CNT_W]);
    end
  end
endmodule

// File: rtl/rd_lat_mon.sv
module rd_lat_mon
  import rd_lat_pkg::*;
#(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CNT_W  = 64,
  parameter int unsigned OUT_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] rd_issue_i,
  input  logic [NUM_CH-1:0] rd_done_i,
  input  logic              csr_we_i,
  input  logic [11:0]       csr_addr_i,
  input  logic [63:0]       csr_wdata_i,
  output logic [63:0]       csr_rdata_o
);
  localparam int unsigned FLAT_W = NUM_CH * CNT_W;

  logic              cnt_en, clr, gate_q;
  logic [CNT_W-1:0]  cyc_cnt;
  logic              cyc_ovf;
  logic [FLAT_W-1:0] req_flat, acc_flat;
  logic [NUM_CH-1:0] req_ovf, acc_ovf;
  logic [NUM_CH*OUT_W-1:0] inflight_flat;
  logic [DATA_W-1:0] status_vec;

  rd_lat_accum #(.CNT_W(CNT_W), .ADD_W(1)) i_cyc (
    .clk_i, .rst_ni, .clr_i(clr), .en_i(cnt_en), .add_i(1'b1),
    .cnt_o(cyc_cnt), .ovf_o(cyc_ovf)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    rd_lat_inflight #(.OUT_W(OUT_W)) i_trk (
      .clk_i, .rst_ni, .issue_i(rd_issue_i[c]), .done_i(rd_done_i[c]),
      .cnt_o(inflight_flat[c*OUT_W +: OUT_W])
    );
    rd_lat_accum #(.CNT_W(CNT_W), .ADD_W(1)) i_req (
      .clk_i, .rst_ni, .clr_i(clr), .en_i(cnt_en), .add_i(rd_issue_i[c]),
      .cnt_o(req_flat[c*CNT_W +: CNT_W]), .ovf_o(req_ovf[c])
    );
    rd_lat_accum #(.CNT_W(CNT_W), .ADD_W(OUT_W)) i_acc (
      .clk_i, .rst_ni, .clr_i(clr), .en_i(cnt_en),
      .add_i(inflight_flat[c*OUT_W +: OUT_W]),
      .cnt_o(acc_flat[c*CNT_W +: CNT_W]), .ovf_o(acc_ovf[c])
    );
  end

  always_comb begin
    status_vec    = '0;
    status_vec[0] = cyc_ovf;
    for (int unsigned c = 0; c < NUM_CH; c++) begin
      status_vec[stat_acc_bit(c)] = acc_ovf[c];
      status_vec[stat_req_bit(c)] = req_ovf[c];
    end
  end

  rd_lat_csr #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) i_csr (
    .clk_i, .rst_ni,
    .we_i(csr_we_i), .addr_i(csr_addr_i), .wdata_i(csr_wdata_i),
    .rdata_o(csr_rdata_o),
    .cyc_i(cyc_cnt), .req_i(req_flat), .acc_i(acc_flat), .stat_i(status_vec),
    .gate_o(gate_q), .cnt_en_o(cnt_en), .clr_o(clr)
  );
endmodule

// File: rtl/rd_lat_mon_chk.sv
module rd_lat_mon_chk #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned OUT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             csr_we_i,
  input logic [11:0]      csr_addr_i,
  input logic [63:0]      csr_wdata_i,
  input logic             issue0,
  input logic             done0,
  input logic             gate_q,
  input logic             cnt_en,
  input logic [CNT_W-1:0] cyc_cnt,
  input logic [OUT_W-1:0] inflight0,
  input logic [63:0]      status
);
  logic clr_cmd;
  assign clr_cmd = csr_we_i && (csr_addr_i == 12'h808) && (csr_wdata_i == 64'd2) && gate_q;

  AST_CYC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cnt_en && !clr_cmd |=> $stable(cyc_cnt)); // R1
  AST_CYC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en && !clr_cmd && (cyc_cnt != '1) |=> cyc_cnt == $past(cyc_cnt) + 1'b1); // R1
  AST_TRK_NET_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue0 && done0 |=> $stable(inflight0)); // R4
  AST_TRK_FLOOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inflight0 == '0) && done0 && !issue0 |=> inflight0 == '0); // R4
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status != '0) && !clr_cmd |=> (status & $past(status)) == $past(status)); // R8
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_cmd |=> (status == '0) && (cyc_cnt == '0)); // R7
endmodule

bind rd_lat_mon rd_lat_mon_chk #(.CNT_W(CNT_W), .OUT_W(OUT_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i), .csr_wdata_i(csr_wdata_i),
  .issue0(rd_issue_i[0]), .done0(rd_done_i[0]),
  .gate_q(gate_q), .cnt_en(cnt_en), .cyc_cnt(cyc_cnt),
  .inflight0(inflight_flat[OUT_W-1:0]), .status(status_vec)
);

// File: tb/test_rd_lat_mon.sv
`timescale 1ns/1ps
module test_rd_lat_mon;
  localparam int CW = 10;
  localparam int OW = 8;
  localparam longint MODV = 1 << CW;
  localparam int TMAX = (1 << OW) - 1;

  logic        clk = 0, rst_n = 0;
  logic [2:0]  iss = 0, dn = 0;
  logic        we = 0;
  logic [11:0] addr = 0;
  logic [63:0] wdata = 0, rdata;

  int checks = 0, errors = 0;

  // reference state
  bit     m_gate, m_run;
  longint m_cyc;
  longint m_req[3], m_acc[3];
  int     m_out[3];
  bit     m_cyc_ov;
  bit     m_req_ov[3], m_acc_ov[3];

  always #10 clk = ~clk;

  rd_lat_mon #(.NUM_CH(3), .CNT_W(CW), .OUT_W(OW)) i_rd_lat_mon (
    .clk_i(clk), .rst_ni(rst_n), .rd_issue_i(iss), .rd_done_i(dn),
    .csr_we_i(we), .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rdata)
  );

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic void bump(ref longint v, input longint inc, ref bit ov);
    v = v + inc;
    if (v >= MODV) begin v = v - MODV; ov = 1; end
  endfunction

  function automatic void model_edge(input logic [2:0] i_s, input logic [2:0] d_s,
                                     input bit w, input logic [11:0] a, input logic [63:0] d);
    bit act, clr;
    act = m_run && m_gate;
    clr = w && a == 12'h808 && d == 64'd2 && m_gate;
    if (act) begin
      bump(m_cyc, 1, m_cyc_ov);
      for (int c = 0; c < 3; c++) begin
        bump(m_req[c], longint'(i_s[c]), m_req_ov[c]);
        bump(m_acc[c], longint'(m_out[c]), m_acc_ov[c]);
      end
    end
    for (int c = 0; c < 3; c++) begin
      if (i_s[c] && !d_s[c] && m_out[c] < TMAX) m_out[c]++;
      else if (d_s[c] && !i_s[c] && m_out[c] > 0) m_out[c]--;
    end
    if (clr) begin
      m_cyc = 0; m_cyc_ov = 0; m_run = 0;
      for (int c = 0; c < 3; c++) begin
        m_req[c] = 0; m_acc[c] = 0; m_req_ov[c] = 0; m_acc_ov[c] = 0;
      end
    end else if (w && a == 12'h808 && d == 64'd0) m_run = 0;
    else if (w && a == 12'h808 && d == 64'd1) m_run = 1;
    if (w && a == 12'h800) m_gate = d[0];
  endfunction

  function automatic logic [63:0] model_stat();
    logic [63:0] s = '0;
    s[0] = m_cyc_ov;
    for (int c = 0; c < 3; c++) begin
      s[1 + 3*c] = m_acc_ov[c];
      s[3 + 3*c] = m_req_ov[c];
    end
    return s;
  endfunction

  task automatic chk(input string tag, input string scen, input logic [11:0] a,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s [%s] @%h: actual %h expected %h", tag, scen, a, act, exp);
    end
  endtask

  task automatic rd(input logic [11:0] a, input string tag, input string scen,
                    input logic [63:0] exp);
    addr = a;
    #0.5;
    chk(tag, scen, a, rdata, exp);
  endtask

  task automatic sweep(input string scen);
    rd(12'h800, "R6", scen, 64'(m_gate));
    rd(12'h808, "R5", scen, 64'(m_run));
    rd(12'h810, "R8", scen, model_stat());
    rd(12'h818, "R1", scen, 64'(m_cyc));
    rd(12'h820, "R2", scen, 64'(m_req[0]));
    rd(12'h838, "R2", scen, 64'(m_req[1]));
    rd(12'h850, "R2", scen, 64'(m_req[2]));
    rd(12'h830, "R3", scen, 64'(m_acc[0]));
    rd(12'h848, "R3", scen, 64'(m_acc[1]));
    rd(12'h860, "R3", scen, 64'(m_acc[2]));
    rd(12'h828, "R9", scen, 64'd0);
    rd(12'h804, "R9", scen, 64'd0);
    rd(12'h000, "R9", scen, 64'd0);
  endtask

  task automatic step(input logic [2:0] i_s, input logic [2:0] d_s, input bit w,
                      input logic [11:0] a, input logic [63:0] d, input string scen);
    iss = i_s; dn = d_s; we = w; addr = a; wdata = d;
    @(posedge clk);
    model_edge(i_s, d_s, w, a, d);
    #1;
    we = 0; iss = 0; dn = 0;
    sweep(scen);
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d, input string scen);
    step(3'b000, 3'b000, 1'b1, a, d, scen);
  endtask

  task automatic idle(input int n, input string scen);
    for (int k = 0; k < n; k++) step(3'b000, 3'b000, 1'b0, 12'h0, 64'd0, scen);
  endtask

  initial begin
    m_gate = 0; m_run = 0; m_cyc = 0; m_cyc_ov = 0;
    for (int c = 0; c < 3; c++) begin
      m_req[c] = 0; m_acc[c] = 0; m_out[c] = 0; m_req_ov[c] = 0; m_acc_ov[c] = 0;
    end
    #35 rst_n = 1;
    #1 sweep("R10 reset");

    // R6 R5: open gate and run
    wr(12'h800, 64'd1, "R6 gate open");
    wr(12'h808, 64'd1, "R5 run");

    // R3 R4: mixed traffic, ch0 sees simultaneous issue/done
    for (int i = 0; i < 80; i++)
      step({i % 5 == 0, i % 3 == 0, i % 2 == 0},
           {i % 7 == 3, i % 4 == 1, i % 3 == 0}, 1'b0, 12'h0, 64'd0, "R3 R4 mixed");
    // R4: completions with nothing in flight
    for (int i = 0; i < 40; i++) step(3'b000, 3'b111, 1'b0, 12'h0, 64'd0, "R4 floor");
    for (int i = 0; i < 6; i++)  step(3'b111, 3'b111, 1'b0, 12'h0, 64'd0, "R4 net zero");

    // R5: stop, traffic keeps the trackers moving, unknown codes ignored
    wr(12'h808, 64'd0, "R5 stop");
    for (int i = 0; i < 5; i++) step(3'b101, 3'b000, 1'b0, 12'h0, 64'd0, "R4 tracking while stopped");
    wr(12'h808, 64'd3, "R5 code 3 ignored");
    wr(12'h808, 64'h1_0000_0001, "R5 wide code ignored");
    wr(12'h808, 64'd1, "R5 rerun");
    idle(8, "R3 latency after stop");

    // R6: gate closed freezes even with run set
    wr(12'h800, 64'd0, "R6 gate close");
    for (int i = 0; i < 5; i++) step(3'b010, 3'b001, 1'b0, 12'h0, 64'd0, "R6 frozen");
    // R7: clear while gated has no effect
    wr(12'h808, 64'd2, "R7 clear gated");
    wr(12'h800, 64'd1, "R6 reopen");
    idle(4, "R6 running");
    // R9: writes to read-only registers
    wr(12'h818, 64'hFFFF, "R9 ro cycles");
    wr(12'h830, 64'hFFFF, "R9 ro acc");
    wr(12'h810, 64'hFFFF, "R9 ro status");
    // R7: clear while ungated, then restart from zero
    wr(12'h808, 64'd2, "R7 clear");
    idle(3, "R7 after clear");
    wr(12'h808, 64'd1, "R7 restart");
    idle(5, "R7 from zero");

    // R8: drive wrap of every counter kind
    for (int i = 0; i < 60; i++) step(3'b100, 3'b000, 1'b0, 12'h0, 64'd0, "R8 fill ch2");
    for (int i = 0; i < 1100; i++)
      step(3'b011, 3'b011, 1'b0, 12'h0, 64'd0, "R8 wrap");
    wr(12'h808, 64'd2, "R8 R7 clear status");
    idle(3, "R8 cleared");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule